// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

The block moves data between a 12-bit narrow port A and a 24-bit wide port B, all in step with one clock. Port B is two 12-bit halves: a low half (1B, bits 11:0) and a high half (2B, bits 23:12). Going from A to B, two narrow words that arrive on consecutive cycles are collected and then shown together as one wide word. The low half goes through a two-stage pipeline and the high half through a single register, so the earlier word sits in 1B and the later word in 2B. Going from B to A, each wide half is captured in its own register, and a registered select chooses which half appears on port A. Each data register has its own active-low capture enable.

Which port drives is set by two active-low output enables. These are registered into a four-state direction machine:

- DIR_OFF: neither port drives.
- DIR_TO_A: port A drives.
- DIR_TO_B: port B drives.
- DIR_BOTH: both ports drive.

On every clock edge the machine moves to the state given by the sampled enable pair, so any of the four states can follow any other. A bus direction change therefore takes effect only at the next rising edge. Before the first edge the direction state is unknown. An optional synchronous reset forces DIR_OFF. Three-state drivers are represented as a data output plus a drive-enable output for each port.

Top module: `bus_xchg_12to24`

## Requirements
- R1: While `rst` is high at a rising edge, `a_oe` and `b_oe` are 0 after that edge, whatever the output-enable inputs are.
- R2: A data register whose capture enable is high at an edge keeps its value. The register and enable pairs are: stage 1 and stage 2 with `cke_a1_n`, the 2B register with `cke_a2_n`, the 1B-to-A register with `cke_b1_n`, and the 2B-to-A register with `cke_b2_n`.
- R3: The A-to-1B path has two stages, and both load when `cke_a1_n` is low. A word on `a_in` appears on `b_out[11:0]` after the second such edge, not after the first.
- R4: The A-to-2B path has one stage. After an edge with `cke_a2_n` low, `b_out[23:12]` equals the `a_in` sampled at that edge.
- R5: Word W1 is loaded with `cke_a1_n`=0 and `cke_a2_n`=1. On the next edge, word W2 is loaded with both enables low. After that edge `b_out` = {W2, W1}.
- R6: An edge with `cke_b1_n` low captures `b_in[11:0]` into the 1B-to-A register. An edge with `cke_b2_n` low captures `b_in[23:12]` into the 2B-to-A register.
- R7: `sel` is registered. After an edge that samples `sel`=0, `a_out` shows the 1B-to-A register. After an edge that samples `sel`=1, it shows the 2B-to-A register. A change of `sel` between edges has no effect on `a_out`.
- R8: `a_oe` is 1 after an edge that samples `oe_a_n`=0 and 0 after an edge that samples `oe_a_n`=1, with `rst` low. A change of `oe_a_n` between edges does not change `a_oe`.
- R9: `b_oe` follows `oe_b_n` in the same registered way.
- R10: The direction machine enters DIR_OFF, DIR_TO_A, DIR_TO_B or DIR_BOTH from any state, as given by the sampled pair (`oe_b_n`, `oe_a_n`) = (1,1), (1,0), (0,1) or (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces DIR_OFF |
| a_in | input | 12 | Narrow port input data |
| a_out | output | 12 | Narrow port output data |
| a_oe | output | 1 | Narrow port drive enable, 1 = driving |
| b_in | input | 24 | Wide port input data |
| b_out | output | 24 | Wide port output data, {2B, 1B} |
| b_oe | output | 1 | Wide port drive enable, 1 = driving |
| cke_a1_n | input | 1 | Active-low enable for the two A-to-1B stages |
| cke_a2_n | input | 1 | Active-low enable for the A-to-2B register |
| cke_b1_n | input | 1 | Active-low enable for the 1B-to-A register |
| cke_b2_n | input | 1 | Active-low enable for the 2B-to-A register |
| sel | input | 1 | Half select for port A (0 = 1B, 1 = 2B), registered |
| oe_a_n | input | 1 | Active-low output enable for port A, registered |
| oe_b_n | input | 1 | Active-low output enable for port B, registered |

## Verification
Two things can happen on the same edge.

- **Second word and stage advance.** The edge that loads the second narrow word into the 2B register also moves the first word into pipeline stage two. The bench provokes this by holding both A-side enables low on that edge, then judges the whole wide word against {W2, W1}.
- **Direction change and data capture.** The bench also lowers `oe_b_n` on that same edge. It then checks that `b_oe` rises on exactly that edge, so the wide word and its drive enable appear together. It also checks that `a_out` and `a_oe` do not move early when `sel` or `oe_a_n` change between edges.

// File: rtl/bus_xchg_pkg.sv
package bus_xchg_pkg;

    localparam int unsigned XCHG_NARROW_W = 12;

    typedef enum logic [1:0] {
        DIR_OFF  = 2'b00,
        DIR_TO_A = 2'b01,
        DIR_TO_B = 2'b10,
        DIR_BOTH = 2'b11
    } dir_state_t;

endpackage

// File: rtl/bus_xchg_dir_ctrl.sv
module bus_xchg_dir_ctrl
    import bus_xchg_pkg::*;
#(
    parameter bit HAS_SYNC_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic a_oe,
    output logic b_oe
);

    dir_state_t state_q;
    dir_state_t state_d;

    // Next state comes straight from the sampled enable pair.
    always_comb begin
        unique case ({oe_b_n, oe_a_n})
            2'b11:   state_d = DIR_OFF;
            2'b10:   state_d = DIR_TO_A;
            2'b01:   state_d = DIR_TO_B;
            default: state_d = DIR_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (HAS_SYNC_RST && rst) begin
            state_q <= DIR_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            DIR_OFF:  begin a_oe = 1'b0; b_oe = 1'b0; end
            DIR_TO_A: begin a_oe = 1'b1; b_oe = 1'b0; end
            DIR_TO_B: begin a_oe = 1'b0; b_oe = 1'b1; end
            default:  begin a_oe = 1'b1; b_oe = 1'b1; end
        endcase
    end

    AST_A_OE_ON:  assert property (@(posedge clk) disable iff (rst) !oe_a_n |=> a_oe);   // R8
    AST_A_OE_OFF: assert property (@(posedge clk) disable iff (rst) oe_a_n |=> !a_oe);   // R8
    AST_B_OE_ON:  assert property (@(posedge clk) disable iff (rst) !oe_b_n |=> b_oe);   // R9
    AST_B_OE_OFF: assert property (@(posedge clk) disable iff (rst) oe_b_n |=> !b_oe);   // R9
    AST_RST_OFF:  assert property (@(posedge clk) (HAS_SYNC_RST && rst) |=> (!a_oe && !b_oe)); // R1

endmodule

// File: rtl/bus_xchg_a2b_path.sv
module bus_xchg_a2b_path #(
    parameter int unsigned NARROW_W = 12,
    localparam int unsigned WIDE_W = 2 * NARROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NARROW_W-1:0] a_in,
    input  logic                cke_a1_n,
    input  logic                cke_a2_n,
    output logic [WIDE_W-1:0]   b_word
);

    logic [NARROW_W-1:0] s1_q;
    logic [NARROW_W-1:0] s2_q;
    logic [NARROW_W-1:0] hi_q;

    // Two-stage pipeline for the low half; both stages share one enable.
    always_ff @(posedge clk) begin
        if (!cke_a1_n) begin
            s1_q <= a_in;
            s2_q <= s1_q;
        end
    end

    // Single register for the high half.
    always_ff @(posedge clk) begin
        if (!cke_a2_n) begin
            hi_q <= a_in;
        end
    end

    assign b_word = {hi_q, s2_q};

    AST_LO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !cke_a1_n |=> b_word[NARROW_W-1:0] == $past(s1_q));              // R3
    AST_HI_LOAD:    assert property (@(posedge clk) disable iff (rst)
        !cke_a2_n |=> b_word[WIDE_W-1:NARROW_W] == $past(a_in));         // R4
    AST_A2B_HOLD:   assert property (@(posedge clk) disable iff (rst)
        (cke_a1_n && cke_a2_n) |=> $stable(b_word));                     // R2

endmodule

// File: rtl/bus_xchg_b2a_path.sv
module bus_xchg_b2a_path #(
    parameter int unsigned NARROW_W = 12,
    localparam int unsigned WIDE_W = 2 * NARROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WIDE_W-1:0]   b_in,
    input  logic                cke_b1_n,
    input  logic                cke_b2_n,
    input  logic                sel,
    output logic [NARROW_W-1:0] a_word
);

    logic [NARROW_W-1:0] lo_q;
    logic [NARROW_W-1:0] hi_q;
    logic                sel_q;

    always_ff @(posedge clk) begin
        if (!cke_b1_n) begin
            lo_q <= b_in[NARROW_W-1:0];
        end
        if (!cke_b2_n) begin
            hi_q <= b_in[WIDE_W-1:NARROW_W];
        end
        sel_q <= sel;
    end

    assign a_word = sel_q ? hi_q : lo_q;

    AST_SEL_HI:  assert property (@(posedge clk) disable iff (rst)
        (sel && !cke_b2_n) |=> a_word == $past(b_in[WIDE_W-1:NARROW_W]));   // R7
    AST_SEL_LO:  assert property (@(posedge clk) disable iff (rst)
        (!sel && !cke_b1_n) |=> a_word == $past(b_in[NARROW_W-1:0]));       // R6
    AST_B2A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cke_b1_n && cke_b2_n && sel == sel_q) |=> $stable(a_word));         // R2

endmodule

// File: rtl/bus_xchg_12to24.sv
module bus_xchg_12to24
    import bus_xchg_pkg::*;
#(
    parameter int unsigned NARROW_W     = XCHG_NARROW_W,
    parameter bit          HAS_SYNC_RST = 1'b1,
    localparam int unsigned WIDE_W      = 2 * NARROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NARROW_W-1:0] a_in,
    output logic [NARROW_W-1:0] a_out,
    output logic                a_oe,
    input  logic [WIDE_W-1:0]   b_in,
    output logic [WIDE_W-1:0]   b_out,
    output logic                b_oe,
    input  logic                cke_a1_n,
    input  logic                cke_a2_n,
    input  logic                cke_b1_n,
    input  logic                cke_b2_n,
    input  logic                sel,
    input  logic                oe_a_n,
    input  logic                oe_b_n
);

    bus_xchg_a2b_path #(.NARROW_W(NARROW_W)) u_a2b (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .cke_a1_n (cke_a1_n),
        .cke_a2_n (cke_a2_n),
        .b_word   (b_out)
    );

    bus_xchg_b2a_path #(.NARROW_W(NARROW_W)) u_b2a (
        .clk      (clk),
        .rst      (rst),
        .b_in     (b_in),
        .cke_b1_n (cke_b1_n),
        .cke_b2_n (cke_b2_n),
        .sel      (sel),
        .a_word   (a_out)
    );

    bus_xchg_dir_ctrl #(.HAS_SYNC_RST(HAS_SYNC_RST)) u_dir (
        .clk    (clk),
        .rst    (rst),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .a_oe   (a_oe),
        .b_oe   (b_oe)
    );

endmodule

// File: tb/bus_xchg_12to24_tb_top.sv
module bus_xchg_12to24_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] a_in;
    logic [11:0] a_out;
    logic        a_oe;
    logic [23:0] b_in;
    logic [23:0] b_out;
    logic        b_oe;
    logic        cke_a1_n, cke_a2_n, cke_b1_n, cke_b2_n;
    logic        sel, oe_a_n, oe_b_n;

    int checks = 0;
    int fails  = 0;

    localparam logic [11:0] W1 = 12'hA5C;
    localparam logic [11:0] W2 = 12'h3E1;

    always #10 clk = ~clk;

    bus_xchg_12to24 dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .cke_a1_n(cke_a1_n), .cke_a2_n(cke_a2_n),
        .cke_b1_n(cke_b1_n), .cke_b2_n(cke_b2_n),
        .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
    );

    // Wait for the next rising edge and settle 5 ns past it.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_enables();
        cke_a1_n = 1'b1; cke_a2_n = 1'b1; cke_b1_n = 1'b1; cke_b2_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        tick();
        check("R1 a_oe in reset", {31'd0, a_oe}, 32'd0);
        check("R1 b_oe in reset", {31'd0, b_oe}, 32'd0);
        rst = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick();
        check("R10 DIR_OFF a_oe", {31'd0, a_oe}, 32'd0);
    endtask

    task automatic t_pair();
        a_in = W1; cke_a1_n = 1'b0; cke_a2_n = 1'b1;
        tick();
        // Second word, stage advance and a port B direction change share one edge.
        a_in = W2; cke_a1_n = 1'b0; cke_a2_n = 1'b0; oe_b_n = 1'b0;
        tick();
        idle_enables();
        check("R5 paired wide word", {8'd0, b_out}, {8'd0, W2, W1});
        check("R9 b_oe with paired word", {31'd0, b_oe}, 32'd1);
        check("R10 DIR_TO_B a_oe", {31'd0, a_oe}, 32'd0);
        a_in = 12'hFFF;
        tick();
        tick();
        check("R2 A-side hold", {8'd0, b_out}, {8'd0, W2, W1});
    endtask

    task automatic t_single_stage();
        a_in = 12'h123; cke_a2_n = 1'b0;
        tick();
        cke_a2_n = 1'b1;
        check("R4 2B single stage", {20'd0, b_out[23:12]}, 32'h123);
        check("R2 1B held", {20'd0, b_out[11:0]}, {20'd0, W1});
    endtask

    task automatic t_two_stage();
        // Stage 1 still holds W2 from the pairing.
        a_in = 12'h456; cke_a1_n = 1'b0;
        tick();
        check("R3 first edge not yet visible", {20'd0, b_out[11:0]}, {20'd0, W2});
        a_in = 12'h789;
        tick();
        cke_a1_n = 1'b1;
        check("R3 second edge visible", {20'd0, b_out[11:0]}, 32'h456);
        check("R2 2B held", {20'd0, b_out[23:12]}, 32'h123);
    endtask

    task automatic t_b2a();
        b_in = 24'hBCD0EF; cke_b1_n = 1'b0; cke_b2_n = 1'b0; sel = 1'b0;
        tick();
        cke_b1_n = 1'b1; cke_b2_n = 1'b1;
        check("R6 1B captured", {20'd0, a_out}, 32'h0EF);
        b_in = 24'h999888; sel = 1'b1;
        #3;
        check("R7 sel between edges", {20'd0, a_out}, 32'h0EF);
        tick();
        check("R7 sel picks 2B", {20'd0, a_out}, 32'hBCD);
        b_in = 24'h111222; cke_b1_n = 1'b0;
        tick();
        cke_b1_n = 1'b1;
        check("R2 2B-to-A held", {20'd0, a_out}, 32'hBCD);
        sel = 1'b0;
        tick();
        check("R6 1B reloaded", {20'd0, a_out}, 32'h222);
        b_in = 24'h777666; cke_b2_n = 1'b0; sel = 1'b1;
        tick();
        cke_b2_n = 1'b1;
        check("R6 2B captured", {20'd0, a_out}, 32'h777);
    endtask

    task automatic t_oe();
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        tick();
        check("R8 a_oe on", {31'd0, a_oe}, 32'd1);
        check("R9 b_oe off", {31'd0, b_oe}, 32'd0);
        oe_b_n = 1'b0;
        tick();
        check("R10 DIR_BOTH", {30'd0, a_oe, b_oe}, 32'd3);
        oe_a_n = 1'b1;
        #3;
        check("R8 a_oe registered", {31'd0, a_oe}, 32'd1);
        tick();
        check("R8 a_oe off", {31'd0, a_oe}, 32'd0);
        oe_a_n = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
        check("R1 reset from DIR_BOTH", {30'd0, a_oe, b_oe}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; a_in = '0; b_in = '0; sel = 1'b0;
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        idle_enables();
        #5;
        tick();
        t_reset();
        t_pair();
        t_single_stage();
        t_two_stage();
        t_b2a();
        t_oe();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule